// File: doc/BRIEF.md
# Oversampling Serial Character Receiver

This block turns an asynchronous serial input line into characters. It runs on the system clock and is paced by a one-cycle enable that pulses eight times per bit period. A falling edge on the idle-high line starts a candidate frame. The candidate is accepted only if the line is still low half a bit later. After that, the line is sampled once near the centre of each data bit, of the optional parity bit and of each stop bit.

Every finished character leaves as a single-cycle push toward an external receive FIFO. The push carries a 32-bit word with the character in the low bits and zeros above, plus one error flag. That flag merges parity mismatches, framing faults and line breaks, so they cannot be told apart. If the FIFO reports full when a character completes, the character is dropped and a separate overrun pulse is raised instead. Character length, stop-bit count and parity mode come from static configuration inputs. These share their encodings with the companion transmitter and are expected to change only while the line is idle.

Top module: `rx_oversampler`

## Requirements
- R1: After reset, `push` and `overrun` are low, and no character is produced while the line stays high.
- R2: A low level on `rx_serial` starts a frame only if the line is still low four ticks after the tick that first saw it low; a shorter low pulse produces neither `push` nor `overrun`.
- R3: Data bits arrive least significant first. `cfg_len` selects the length: 0 means 5 bits, 1 means 6, 2 means 7 and 3 means 8. The character sits in `push_word[7:0]` with the unused high bits zero, and `push_word[31:8]` is zero.
- R4: `cfg_parity` selects the parity mode: 4 is odd, 6 is even, 5 is mark (the parity bit must be 1) and 7 is space (it must be 0). Codes 0 to 3 mean no parity bit. A mismatching parity bit sets `push_err`, and the character is still delivered.
- R5: With `cfg_two_stop` low, one stop bit is sampled; with it high, two are sampled. Any stop sample that is low sets `push_err`.
- R6: A break (all data bits zero with a low stop bit) is delivered once as data 0 with `push_err` set. After any frame that ends with the line low, no new frame starts until the line has returned high.
- R7: If `fifo_full` is high in the cycle a character completes, `push` stays low and `overrun` pulses for one cycle. `push` and `overrun` are never high together.
- R8: Each accepted character produces exactly one single-cycle `push`. It is registered in the cycle after the tick that sampled the last stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_x8 | input | 1 | Sample enable, eight pulses per bit period |
| rx_serial | input | 1 | Asynchronous serial input, idle high |
| cfg_len | input | 2 | Character length code (0..3 = 5..8 bits) |
| cfg_two_stop | input | 1 | 1 = two stop bits, 0 = one |
| cfg_parity | input | 3 | Parity mode code |
| fifo_full | input | 1 | Receive FIFO cannot accept a word |
| push | output | 1 | One-cycle write strobe toward the FIFO |
| push_word | output | 32 | Received character, zero-extended |
| push_err | output | 1 | Shared parity/framing/break error for this word |
| overrun | output | 1 | One-cycle pulse: character dropped, FIFO full |

## Verification
The assertions check on every cycle the rules that hold regardless of line content. These are: push and overrun are mutually exclusive, each follows a tick, push is a single-cycle pulse, the high word bits are zero, short characters are zero-extended, and the overrun/push choice follows the full flag. Whether the character value and the error flag are right depends on bit timing on the line. Only the bench scenarios can show this: glitch rejection, each length and parity code, injected parity and stop faults, a long break followed by normal traffic, and a frame arriving while the FIFO is full.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP1 = 3'd4,
        ST_STOP2 = 3'd5,
        ST_HOLD  = 3'd6
    } rx_state_e;

    // Parity mode codes shared with the transmitter: bit 2 enables parity,
    // bit 0 selects a fixed level, bit 1 selects even or space.
    localparam logic [2:0] PAR_NONE  = 3'b000;
    localparam logic [2:0] PAR_ODD   = 3'b100;
    localparam logic [2:0] PAR_MARK  = 3'b101;
    localparam logic [2:0] PAR_EVEN  = 3'b110;
    localparam logic [2:0] PAR_SPACE = 3'b111;

endpackage

// File: rtl/rxs_sync.sv
// Multi-flop synchronizer for the asynchronous line; resets to the idle level.
module rxs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/rxs_parity.sv
// Decodes the parity mode and produces the bit the line must carry.
// The character arrives zero-extended, so a full-width reduction is exact.
module rxs_parity #(
    parameter int DATA_MAX = 8
) (
    input  logic [2:0]          mode,
    input  logic [DATA_MAX-1:0] data,
    output logic                enable,
    output logic                expect_bit
);

    logic ones_odd;

    always_comb begin
        ones_odd   = ^data;
        enable     = mode[2];
        expect_bit = 1'b0;
        if (mode[0]) begin
            // fixed level: mark -> 1, space -> 0
            expect_bit = ~mode[1];
        end else if (mode[1]) begin
            // even: total count of ones including parity is even
            expect_bit = ones_odd;
        end else begin
            // odd: total count of ones including parity is odd
            expect_bit = ~ones_odd;
        end
    end

endmodule

// File: rtl/rxs_framer.sv
// Frame state machine: start qualification, centre sampling, parity and
// stop checks, push or overrun decision.
module rxs_framer
    import rxs_pkg::*;
#(
    parameter int OVS      = 8,
    parameter int QUAL     = 4,
    parameter int DATA_MAX = 8,
    parameter int LEN_W    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                line,
    input  logic [LEN_W-1:0]    cfg_len,
    input  logic                cfg_two_stop,
    input  logic                par_en,
    input  logic                par_exp,
    input  logic                fifo_full,
    output logic [DATA_MAX-1:0] data_q,
    output logic                err_q,
    output logic                push_q,
    output logic                ovr_q
);

    localparam int CNT_W    = $clog2(OVS);
    localparam int IDX_W    = $clog2(DATA_MAX);
    localparam int MIN_BITS = DATA_MAX - (2 ** LEN_W) + 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
    localparam logic [CNT_W-1:0] CNT_QUAL = CNT_W'(QUAL - 1);

    typedef struct packed {
        rx_state_e           st;
        logic [CNT_W-1:0]    cnt;
        logic [IDX_W-1:0]    idx;
        logic [DATA_MAX-1:0] data;
        logic                err;
        logic                push;
        logic                ovr;
    } frame_t;

    localparam frame_t FRAME_RST = '{
        st:   ST_IDLE,
        cnt:  '0,
        idx:  '0,
        data: '0,
        err:  1'b0,
        push: 1'b0,
        ovr:  1'b0
    };

    frame_t           fr_d, fr_q;
    logic             bit_due;
    logic             finish;
    logic [IDX_W-1:0] last_idx;

    always_comb begin
        fr_d     = fr_q;
        fr_d.push = 1'b0;
        fr_d.ovr  = 1'b0;
        finish   = 1'b0;
        last_idx = IDX_W'(MIN_BITS - 1) + IDX_W'(cfg_len);
        bit_due  = tick && (fr_q.cnt == CNT_LAST);

        // bit-period counter runs in every sampling state
        if (tick && (fr_q.st inside {ST_DATA, ST_PAR, ST_STOP1, ST_STOP2})) begin
            fr_d.cnt = bit_due ? '0 : fr_q.cnt + 1'b1;
        end

        case (fr_q.st)
            ST_IDLE: begin
                if (tick && !line) begin
                    fr_d.st  = ST_START;
                    fr_d.cnt = '0;
                end
            end
            ST_START: begin
                if (tick) begin
                    if (fr_q.cnt == CNT_QUAL) begin
                        if (line) begin
                            fr_d.st = ST_IDLE;
                        end else begin
                            fr_d.st   = ST_DATA;
                            fr_d.cnt  = '0;
                            fr_d.idx  = '0;
                            fr_d.data = '0;
                            fr_d.err  = 1'b0;
                        end
                    end else begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (bit_due) begin
                    fr_d.data[fr_q.idx] = line;
                    if (fr_q.idx == last_idx) begin
                        fr_d.st = par_en ? ST_PAR : ST_STOP1;
                    end else begin
                        fr_d.idx = fr_q.idx + 1'b1;
                    end
                end
            end
            ST_PAR: begin
                if (bit_due) begin
                    if (line != par_exp) begin
                        fr_d.err = 1'b1;
                    end
                    fr_d.st = ST_STOP1;
                end
            end
            ST_STOP1: begin
                if (bit_due) begin
                    if (!line) begin
                        fr_d.err = 1'b1;
                    end
                    if (cfg_two_stop) begin
                        fr_d.st = ST_STOP2;
                    end else begin
                        finish = 1'b1;
                    end
                end
            end
            ST_STOP2: begin
                if (bit_due) begin
                    if (!line) begin
                        fr_d.err = 1'b1;
                    end
                    finish = 1'b1;
                end
            end
            ST_HOLD: begin
                if (line) begin
                    fr_d.st = ST_IDLE;
                end
            end
            default: begin
                fr_d.st = ST_IDLE;
            end
        endcase

        if (finish) begin
            if (fifo_full) begin
                fr_d.ovr = 1'b1;
            end else begin
                fr_d.push = 1'b1;
            end
            // a low final stop (break or framing fault) must see the line
            // return high before another start can be taken
            fr_d.st = line ? ST_IDLE : ST_HOLD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q <= FRAME_RST;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign data_q = fr_q.data;
    assign err_q  = fr_q.err;
    assign push_q = fr_q.push;
    assign ovr_q  = fr_q.ovr;

endmodule

// File: rtl/rx_oversampler.sv
module rx_oversampler #(
    parameter int OVS         = 8,
    parameter int QUAL        = 4,
    parameter int DATA_MAX    = 8,
    parameter int LEN_W       = 2,
    parameter int WORD_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_x8,
    input  logic              rx_serial,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_two_stop,
    input  logic [2:0]        cfg_parity,
    input  logic              fifo_full,
    output logic              push,
    output logic [WORD_W-1:0] push_word,
    output logic              push_err,
    output logic              overrun
);

    localparam int PAD_W = WORD_W - DATA_MAX;

    logic                line_s;
    logic                par_en;
    logic                par_exp;
    logic [DATA_MAX-1:0] char_q;

    rxs_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_serial),
        .dout (line_s)
    );

    rxs_parity #(
        .DATA_MAX(DATA_MAX)
    ) u_parity (
        .mode      (cfg_parity),
        .data      (char_q),
        .enable    (par_en),
        .expect_bit(par_exp)
    );

    rxs_framer #(
        .OVS     (OVS),
        .QUAL    (QUAL),
        .DATA_MAX(DATA_MAX),
        .LEN_W   (LEN_W)
    ) u_framer (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick_x8),
        .line        (line_s),
        .cfg_len     (cfg_len),
        .cfg_two_stop(cfg_two_stop),
        .par_en      (par_en),
        .par_exp     (par_exp),
        .fifo_full   (fifo_full),
        .data_q      (char_q),
        .err_q       (push_err),
        .push_q      (push),
        .ovr_q       (overrun)
    );

    assign push_word = {{PAD_W{1'b0}}, char_q};

endmodule

// File: rtl/rxs_checker.sv
module rxs_checker #(
    parameter int DATA_MAX = 8,
    parameter int LEN_W    = 2,
    parameter int WORD_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_x8,
    input logic              fifo_full,
    input logic [LEN_W-1:0]  cfg_len,
    input logic              push,
    input logic [WORD_W-1:0] push_word,
    input logic              overrun
);

    AST_PUSH_OVR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && overrun)); // R7

    AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> $past(fifo_full)); // R7

    AST_PUSH_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !$past(fifo_full)); // R7

    AST_WORD_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (push_word[WORD_W-1:DATA_MAX] == '0)); // R3

    AST_SHORT_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (push && (cfg_len == '0)) |-> (push_word[DATA_MAX-1:5] == '0)); // R3

    AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !push); // R8

    AST_EVENT_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (push || overrun) |-> $past(tick_x8)); // R8

endmodule

bind rx_oversampler rxs_checker #(
    .DATA_MAX(DATA_MAX),
    .LEN_W   (LEN_W),
    .WORD_W  (WORD_W)
) u_rxs_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_x8  (tick_x8),
    .fifo_full(fifo_full),
    .cfg_len  (cfg_len),
    .push     (push),
    .push_word(push_word),
    .overrun  (overrun)
);

// File: tb/rx_oversampler_bench.sv
`timescale 1ns/1ps
module rx_oversampler_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_x8 = 1'b0;
    logic        rx_serial = 1'b1;
    logic [1:0]  cfg_len = 2'd3;
    logic        cfg_two_stop = 1'b0;
    logic [2:0]  cfg_parity = 3'd0;
    logic        fifo_full = 1'b0;
    logic        push;
    logic [31:0] push_word;
    logic        push_err;
    logic        overrun;

    int          n_checks = 0;
    int          n_errors = 0;
    int          n_push = 0;
    int          n_ovr = 0;
    logic [31:0] last_word = '0;
    logic        last_err = 1'b0;
    logic [1:0]  div = '0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    rx_oversampler u_rx_oversampler (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_x8     (tick_x8),
        .rx_serial   (rx_serial),
        .cfg_len     (cfg_len),
        .cfg_two_stop(cfg_two_stop),
        .cfg_parity  (cfg_parity),
        .fifo_full   (fifo_full),
        .push        (push),
        .push_word   (push_word),
        .push_err    (push_err),
        .overrun     (overrun)
    );

    // sample enable: one pulse every four clocks
    always @(posedge clk) begin
        div     <= div + 2'd1;
        tick_x8 <= (div == 2'd3);
    end

    // output monitor, away from the active edge
    always @(negedge clk) begin
        if (rst_n && push) begin
            n_push    <= n_push + 1;
            last_word <= push_word;
            last_err  <= push_err;
        end
        if (rst_n && overrun) begin
            n_ovr <= n_ovr + 1;
        end
    end

    function automatic logic par_bit(input logic [2:0] mode, input logic [7:0] d);
        if (mode[0]) return ~mode[1];
        if (mode[1]) return ^d;
        return ~(^d);
    endfunction

    function automatic logic [31:0] masked(input logic [7:0] d, input logic [1:0] len);
        logic [7:0] m;
        m = 8'hFF >> (3 - len);
        return {24'h0, d & m};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (n) begin
            @(negedge clk);
            while (tick_x8 !== 1'b1) @(negedge clk);
        end
    endtask

    task automatic drive_frame(input logic [7:0] d, input logic [1:0] len,
                               input logic [2:0] par, input logic two,
                               input logic flip_par, input logic bad_stop);
        cfg_len      = len;
        cfg_parity   = par;
        cfg_two_stop = two;
        wait_ticks(2);
        rx_serial = 1'b0;
        wait_ticks(8);
        for (int i = 0; i < 5 + int'(len); i++) begin
            rx_serial = d[i];
            wait_ticks(8);
        end
        if (par[2]) begin
            rx_serial = par_bit(par, masked(d, len)) ^ flip_par;
            wait_ticks(8);
        end
        if (two) begin
            rx_serial = 1'b1;
            wait_ticks(8);
        end
        rx_serial = ~bad_stop;
        wait_ticks(8);
        rx_serial = 1'b1;
        wait_ticks(10);
    endtask

    task automatic frame_and_check(input string tag, input logic [7:0] d,
                                   input logic [1:0] len, input logic [2:0] par,
                                   input logic two, input logic flip_par,
                                   input logic bad_stop);
        int p0;
        p0 = n_push;
        drive_frame(d, len, par, two, flip_par, bad_stop);
        check({tag, " R8 push count"}, 32'(n_push - p0), 32'd1);
        if (n_push == p0 + 1) begin
            check({tag, " R3 word"}, last_word, masked(d, len));
            check({tag, " R4/R5 err"}, 32'(last_err),
                  32'((flip_par & par[2]) | bad_stop));
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 push in reset", 32'(push), 32'd0);
        check("R1 overrun in reset", 32'(overrun), 32'd0);
        rst_n = 1'b1;
        wait_ticks(24);
        check("R1 idle line no push", 32'(n_push), 32'd0);
        check("R1 idle line no overrun", 32'(n_ovr), 32'd0);

        // R2: short low glitch rejected
        begin
            int p0;
            p0 = n_push + n_ovr;
            rx_serial = 1'b0;
            wait_ticks(2);
            rx_serial = 1'b1;
            wait_ticks(120);
            check("R2 glitch ignored", 32'(n_push + n_ovr - p0), 32'd0);
        end

        // R3: lengths and zero extension
        frame_and_check("R3 len5", 8'hFF, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0);
        frame_and_check("R3 len6", 8'hEA, 2'd1, 3'd0, 1'b0, 1'b0, 1'b0);
        frame_and_check("R3 len7", 8'h95, 2'd2, 3'd0, 1'b0, 1'b0, 1'b0);
        frame_and_check("R3 len8", 8'hA5, 2'd3, 3'd0, 1'b0, 1'b0, 1'b0);

        // R4: each parity code, good and bad
        frame_and_check("R4 odd ok", 8'h37, 2'd3, 3'd4, 1'b0, 1'b0, 1'b0);
        frame_and_check("R4 even bad", 8'h37, 2'd3, 3'd6, 1'b0, 1'b1, 1'b0);
        frame_and_check("R4 mark ok", 8'h11, 2'd2, 3'd5, 1'b0, 1'b0, 1'b0);
        frame_and_check("R4 space bad", 8'h11, 2'd2, 3'd7, 1'b0, 1'b1, 1'b0);
        frame_and_check("R4 code2 none", 8'h5C, 2'd3, 3'd2, 1'b0, 1'b0, 1'b0);

        // R5: two stop bits and framing fault
        frame_and_check("R5 two stop ok", 8'hC3, 2'd3, 3'd6, 1'b1, 1'b0, 1'b0);
        frame_and_check("R5 two stop bad", 8'hC3, 2'd3, 3'd0, 1'b1, 1'b0, 1'b1);
        frame_and_check("R5 one stop bad", 8'h7E, 2'd3, 3'd0, 1'b0, 1'b0, 1'b1);

        // R6: long break delivered once, then normal traffic
        begin
            int p0;
            p0 = n_push;
            cfg_len = 2'd3; cfg_parity = 3'd0; cfg_two_stop = 1'b0;
            wait_ticks(2);
            rx_serial = 1'b0;
            wait_ticks(10 * 8 + 60);
            rx_serial = 1'b1;
            wait_ticks(16);
            check("R6 break single push", 32'(n_push - p0), 32'd1);
            check("R6 break word", last_word, 32'd0);
            check("R6 break err", 32'(last_err), 32'd1);
            frame_and_check("R6 after break", 8'h5A, 2'd3, 3'd0, 1'b0, 1'b0, 1'b0);
        end

        // R7: overrun when FIFO full
        begin
            int p0;
            int o0;
            p0 = n_push;
            o0 = n_ovr;
            fifo_full = 1'b1;
            drive_frame(8'h42, 2'd3, 3'd0, 1'b0, 1'b0, 1'b0);
            fifo_full = 1'b0;
            check("R7 overrun count", 32'(n_ovr - o0), 32'd1);
            check("R7 no push while full", 32'(n_push - p0), 32'd0);
            frame_and_check("R7 after overrun", 8'h24, 2'd3, 3'd0, 1'b0, 1'b0, 1'b0);
        end

        // random frames
        for (int k = 0; k < 40; k++) begin
            logic [7:0] d;
            logic [1:0] len;
            logic [2:0] par;
            logic       two;
            logic       flip;
            logic       bad;
            d    = 8'($urandom);
            len  = 2'($urandom_range(0, 3));
            par  = 3'($urandom_range(0, 7));
            two  = 1'($urandom_range(0, 1));
            flip = ($urandom_range(0, 4) == 0);
            bad  = ($urandom_range(0, 6) == 0);
            frame_and_check("R8 random", d, len, par, two, flip, bad);
        end

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog R8 actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule